// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address by fetching one entry from a flat translation table kept in physical memory. The table's start address comes from a base-address input. The walker samples that input when it accepts a request. The virtual page number (the address bits above the page offset) selects one 32-bit entry. The entry's address is the base plus four times the page number.

The walker then makes exactly one read through a simple valid/ready request channel and a valid-qualified response channel. It decodes the returned word and reports the result with a single-cycle completion pulse. If the entry is marked present, the result carries the physical page number, the access-rights code and the full physical address, which is the page number joined to the unchanged page offset. If the entry is not present, the result is a page fault and no translation.

A new request is taken only while the walker is idle, so a processor-side unit can simply hold a request until `req_ready` is high.

Top module: `pgw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `done` and `fault` are 0.
- R2: The entry address on `mem_req_addr` equals `base_addr + 4 * req_va[31:12]`, modulo 2^32. `base_addr` is the value sampled in the accepting cycle.
- R3: Each accepted request produces exactly one memory read handshake. `req_valid` is ignored while `req_ready` is 0, and such a request produces neither a read nor a result.
- R4: The entry word is decoded as follows: bit 31 is the present flag, bits 21:20 are the access-rights code and bits 19:0 are the physical page number. All other bits are ignored.
- R5: For a present entry, `done` rises with `fault` = 0. `ppn_out` and `rights_out` come from the entry, and `pa_out` = {page number, `req_va[11:0]`}.
- R6: For an entry whose present flag is 0, `done` rises with `fault` = 1, and `ppn_out`, `rights_out` and `pa_out` are all 0.
- R7: `done` is high for exactly one cycle, the cycle after the response is accepted. `req_ready` is 1 in the following cycle.
- R8: `mem_rsp_valid` is ignored unless the walker is waiting for a response, and a response at any other time produces no `done`.
- R9: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted and `mem_req_addr` stays unchanged.
- R10: Changes to `base_addr` or `req_va` after acceptance do not affect the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 32 | Physical start address of the translation table |
| req_valid | input | 1 | Translation request present |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle and able to accept a request |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| done | output | 1 | Single-cycle result strobe |
| fault | output | 1 | Page fault, qualified by done |
| ppn_out | output | 20 | Physical page number, qualified by done |
| rights_out | output | 2 | Access-rights code, qualified by done |
| pa_out | output | 32 | Translated physical address, qualified by done |

## Verification
The bench walks the largest page number, page number zero, a table base close to the top of the address space, and entries whose ignored bits are all set. These cases catch an address adder that truncates, drops the scaling by four, or fails to wrap. Memory stalls and response delays vary from walk to walk. A walker that moves its address during a stall, or that reads twice, would break the address and read-count checks.

During a walk the bench drives junk request and base values, and while the walker is idle it sends a stray response. A design that samples its inputs late, or that accepts a response when it is not waiting for one, would produce a wrong or extra result. Entries with the present flag cleared but every other bit set show whether stale fields leak out on a fault.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_READ = 2'd1,
      ST_WAIT = 2'd2,
      ST_DONE = 2'd3
   } walk_state_t;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
   parameter int PA_W          = 32,
   parameter int VPN_W         = 20,
   parameter int PTE_W         = 32,
   parameter bit TABLE_ALIGNED = 1'b0
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  addr
);
   localparam int PTE_BYTES = PTE_W / 8;
   localparam int SH        = $clog2(PTE_BYTES);

   if (PA_W <= VPN_W + SH) begin : g_chk_width
      $error("pgw_entry_addr: PA_W too narrow for the table index");
   end

   if (TABLE_ALIGNED) begin : g_concat
      // base aligned to the table size: index bits replace the low base bits
      logic unused_base_low;
      assign unused_base_low = ^base[VPN_W+SH-1:0];
      assign addr = {base[PA_W-1:VPN_W+SH], vpn, {SH{1'b0}}};
   end else begin : g_adder
      logic [PA_W-1:0] offset;
      assign offset = PA_W'(vpn) << SH;
      assign addr   = base + offset;
   end
endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
   import pgw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic mem_req_ready,
   input  logic mem_rsp_valid,
   output logic accept,
   output logic rsp_take,
   output logic req_ready,
   output logic mem_req_valid,
   output logic done
);
   walk_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (req_valid)     state_d = ST_READ;
         ST_READ: if (mem_req_ready) state_d = ST_WAIT;
         ST_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
         ST_DONE:                    state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign req_ready     = (state_q == ST_IDLE);
   assign accept        = req_ready && req_valid;
   assign mem_req_valid = (state_q == ST_READ);
   assign rsp_take      = (state_q == ST_WAIT) && mem_rsp_valid;
   assign done          = (state_q == ST_DONE);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!mem_req_valid && !done));
   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
   // R3
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && req_ready));
   // R8
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mem_rsp_valid));
endmodule

// File: rtl/pgw_result.sv
module pgw_result #(
   parameter int PTE_W    = 32,
   parameter int PPN_W    = 20,
   parameter int RIGHTS_W = 2,
   parameter int OFF_W    = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rsp_take,
   input  logic [PTE_W-1:0]       rsp_data,
   input  logic                   done,
   input  logic [OFF_W-1:0]       offset,
   output logic                   fault,
   output logic [PPN_W-1:0]       ppn,
   output logic [RIGHTS_W-1:0]    rights,
   output logic [PPN_W+OFF_W-1:0] pa
);
   localparam int VALID_BIT = PTE_W - 1;
   localparam int USED_W    = PPN_W + RIGHTS_W;
   localparam int GAP_W     = VALID_BIT - USED_W;

   logic                present_q;
   logic [USED_W-1:0]   fields_q;

   if (GAP_W > 0) begin : g_gap
      logic unused_gap;
      assign unused_gap = ^rsp_data[VALID_BIT-1:USED_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         present_q <= 1'b0;
         fields_q  <= '0;
      end else if (rsp_take) begin
         present_q <= rsp_data[VALID_BIT];
         fields_q  <= rsp_data[USED_W-1:0];
      end
   end

   logic hit;
   assign hit = done && present_q;

   always_comb begin
      fault  = done && !present_q;
      ppn    = hit ? fields_q[PPN_W-1:0]        : '0;
      rights = hit ? fields_q[PPN_W +: RIGHTS_W] : '0;
      pa     = hit ? {fields_q[PPN_W-1:0], offset} : '0;
   end
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
   parameter int VA_W          = 32,
   parameter int OFF_W         = 12,
   parameter int PA_W          = 32,
   parameter int PTE_W         = 32,
   parameter int PPN_W         = 20,
   parameter int RIGHTS_W      = 2,
   parameter bit TABLE_ALIGNED = 1'b0,
   localparam int VPN_W        = VA_W - OFF_W,
   localparam int PHYS_W       = PPN_W + OFF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PA_W-1:0]     base_addr,
   input  logic                req_valid,
   input  logic [VA_W-1:0]     req_va,
   output logic                req_ready,
   output logic                mem_req_valid,
   output logic [PA_W-1:0]     mem_req_addr,
   input  logic                mem_req_ready,
   input  logic                mem_rsp_valid,
   input  logic [PTE_W-1:0]    mem_rsp_data,
   output logic                done,
   output logic                fault,
   output logic [PPN_W-1:0]    ppn_out,
   output logic [RIGHTS_W-1:0] rights_out,
   output logic [PHYS_W-1:0]   pa_out
);
   if (PPN_W + RIGHTS_W + 1 > PTE_W) begin : g_bad_entry
      $error("pgw_walker: entry word too narrow for its fields");
   end
   if ((PTE_W % 8) != 0 || (PTE_W & (PTE_W - 1)) != 0) begin : g_bad_pte
      $error("pgw_walker: PTE_W must be a power-of-two byte multiple");
   end
   if (OFF_W >= VA_W) begin : g_bad_off
      $error("pgw_walker: page offset wider than the address");
   end

   logic            accept, rsp_take;
   logic [VA_W-1:0] va_q;
   logic [PA_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         va_q   <= '0;
         base_q <= '0;
      end else if (accept) begin
         va_q   <= req_va;
         base_q <= base_addr;
      end
   end

   pgw_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .accept        (accept),
      .rsp_take      (rsp_take),
      .req_ready     (req_ready),
      .mem_req_valid (mem_req_valid),
      .done          (done)
   );

   pgw_entry_addr #(
      .PA_W          (PA_W),
      .VPN_W         (VPN_W),
      .PTE_W         (PTE_W),
      .TABLE_ALIGNED (TABLE_ALIGNED)
   ) u_addr (
      .base (base_q),
      .vpn  (va_q[VA_W-1:OFF_W]),
      .addr (mem_req_addr)
   );

   pgw_result #(
      .PTE_W    (PTE_W),
      .PPN_W    (PPN_W),
      .RIGHTS_W (RIGHTS_W),
      .OFF_W    (OFF_W)
   ) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsp_take (rsp_take),
      .rsp_data (mem_rsp_data),
      .done     (done),
      .offset   (va_q[OFF_W-1:0]),
      .fault    (fault),
      .ppn      (ppn_out),
      .rights   (rights_out),
      .pa       (pa_out)
   );

   // R9
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> $stable(mem_req_addr));
   // R6
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (done && ppn_out == '0 && rights_out == '0 && pa_out == '0));
   // R1
   no_fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !fault);
endmodule

// File: tb/sim_pgw_walker.sv
module sim_pgw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_addr = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done, fault;
   logic [19:0] ppn_out;
   logic [1:0]  rights_out;
   logic [31:0] pa_out;

   always #5 clk = ~clk;

   pgw_walker u0 (
      .clk(clk), .rst_n(rst_n), .base_addr(base_addr),
      .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
      .ppn_out(ppn_out), .rights_out(rights_out), .pa_out(pa_out)
   );

   typedef struct packed {
      logic        fault;
      logic [19:0] ppn;
      logic [1:0]  rights;
      logic [31:0] pa;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] addr_q[$];
   logic [31:0] mem_tbl [logic [31:0]];
   int vectors = 0;
   int miscompares = 0;
   int walks = 0;
   int reads = 0;
   bit spur_go = 1'b0;
   bit spur_done = 1'b0;

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: issues a walk and pushes the expected result
   task automatic walk(input logic [31:0] base, input logic [31:0] va,
                       input logic [31:0] entry, input bit junk);
      logic [31:0] a;
      exp_t e;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      a = base + {10'd0, va[31:12], 2'b00};
      mem_tbl[a] = entry;
      addr_q.push_back(a);
      e.fault  = ~entry[31];
      e.ppn    = entry[31] ? entry[19:0]  : 20'd0;
      e.rights = entry[31] ? entry[21:20] : 2'd0;
      e.pa     = entry[31] ? {entry[19:0], va[11:0]} : 32'd0;
      exp_q.push_back(e);
      walks++;
      req_valid = 1'b1;
      req_va    = va;
      base_addr = base;
      @(negedge clk);
      if (junk) begin
         // R3 / R10: request and base change while busy
         req_va    = ~va;
         base_addr = base ^ 32'h00F0_0F00;
         @(negedge clk);
         chk(!req_ready, "R3 busy not ready", {63'd0, req_ready}, 64'd0);
      end
      req_valid = 1'b0;
      base_addr = 32'h5A5A_5A5A;
   endtask

   // memory responder with varying stall and latency
   initial begin
      int stall = 0;
      int lat = 0;
      logic [31:0] a0;
      forever begin
         @(negedge clk);
         if (spur_go && !spur_done) begin
            // R8: stray response while idle
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'h8012_3456;
            @(negedge clk);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            spur_done = 1'b1;
         end else if (rst_n && mem_req_valid) begin
            a0 = mem_req_addr;
            if (addr_q.size() == 0) begin
               chk(1'b0, "R3 read without walk", {32'd0, a0}, 64'd0);
            end else begin
               chk(a0 == addr_q[0], "R2 entry address", {32'd0, a0}, {32'd0, addr_q[0]});
               void'(addr_q.pop_front());
            end
            for (int i = 0; i < stall; i++) begin
               @(negedge clk);
               chk(mem_req_valid && mem_req_addr == a0, "R9 held request",
                   {31'd0, mem_req_valid, mem_req_addr}, {31'd0, 1'b1, a0});
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            reads++;
            chk(!mem_req_valid, "R3 single read", {63'd0, mem_req_valid}, 64'd0);
            for (int i = 0; i < lat; i++) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_tbl.exists(a0) ? mem_tbl[a0] : 32'h0;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'hFFFF_FFFF;
            stall = (stall + 1) % 3;
            lat   = (lat + 2) % 4;
         end
      end
   end

   // monitor: pops expected results as done pulses appear
   initial begin
      bit prev_done = 1'b0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (prev_done) begin
               chk(!done && req_ready, "R7 pulse width and ready",
                   {62'd0, done, req_ready}, 64'd1);
            end
            if (done) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R8 unexpected done", 64'd1, 64'd0);
               end else begin
                  e = exp_q.pop_front();
                  chk(fault == e.fault, e.fault ? "R6 fault" : "R5 fault",
                      {63'd0, fault}, {63'd0, e.fault});
                  chk(ppn_out == e.ppn && rights_out == e.rights,
                      e.fault ? "R6 fields zero" : "R4 R5 fields",
                      {42'd0, rights_out, ppn_out}, {42'd0, e.rights, e.ppn});
                  chk(pa_out == e.pa, e.fault ? "R6 pa zero" : "R5 R10 pa",
                      {32'd0, pa_out}, {32'd0, e.pa});
               end
            end else begin
               chk(!fault, "R1 fault idle", {63'd0, fault}, 64'd0);
            end
            prev_done = done;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(req_ready && !mem_req_valid && !done && !fault, "R1 reset state",
          {60'd0, req_ready, mem_req_valid, done, fault}, 64'h8);
      walk(32'h0010_0000, 32'h0000_3ABC, 32'h8011_2345, 1'b0);
      walk(32'h0010_0000, 32'h0040_1FFF, 32'h7FFF_FFFF, 1'b0);
      walk(32'h0800_0000, 32'hFFFF_F000, 32'h803F_FFFF, 1'b0);
      walk(32'h0000_1000, 32'h0000_0FFF, 32'h8000_0000, 1'b0);
      walk(32'h0020_0000, 32'h1234_5678, 32'hFFEA_BCDE, 1'b1);
      walk(32'hFFFF_FF00, 32'h0010_0123, 32'h8010_0042, 1'b0);
      for (int k = 0; k < 8; k++) begin
         walk(32'h0100_0000 + 32'(k) * 32'h40,
              32'(k) * 32'h0123_4567 + 32'h0000_0ABC,
              {k[0], 9'h1FF, k[2:1], 20'(k * 32'h1_1111)}, k[1]);
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
      spur_go = 1'b1;
      while (!spur_done) @(negedge clk);
      repeat (4) @(negedge clk);
      // R8
      chk(exp_q.size() == 0 && !done, "R8 stray response", {63'd0, done}, 64'd0);
      // R3
      chk(reads == walks, "R3 read count", 64'(reads), 64'(walks));
      chk(addr_q.size() == 0, "R2 all addresses seen", 64'(addr_q.size()), 64'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule